// File: doc/BRIEF.md
# Boundary Scan Register Chain

This block is the boundary-scan data register that sits between a chip's core logic and its pads. Every output pin owns two scan cells, a driver-enable cell and a data cell. Every input pin owns one cell. All cells form a single serial path from `tdi` to `tdo`. A separate TAP controller supplies the capture, shift and update strobes and selects the external-test or internal-test mode. The TAP state machine, the instruction register and the pads are not part of this block.

On a rising `tck` edge the cells can capture what the core is driving and what the pads are presenting. The same edge can instead shift the whole chain one position toward `tdo`. On a falling `tck` edge an update strobe copies the chain into a bank of update latches. In external-test mode those latches drive the output pads. In internal-test mode they also feed the core's input pins. In functional mode the pins pass straight between core and pads, and the latches have no effect. This is also the mode in which vectors are normally preloaded.

Top module: `bsr_chain`

## Requirements
- R1: Cell positions are counted from the `tdi` end. The enable cell of output pin k is cell 2k and its data cell is 2k+1. Input pin j is cell 2·N_OUT+j. `tdo` always shows the highest-numbered cell.
- R2: While `trst_n` is low, every scan cell and every update latch is 0. `trst_n` low resets asynchronously, and the release takes effect two rising `tck` edges after `trst_n` rises. With zeroed latches, test mode drives every `pad_oe` and `pad_do` to 0.
- R3: A rising `tck` edge with `shift_dr`=1 and `capture_dr`=0 moves every cell one position toward `tdo`, and cell 0 takes `tdi`.
- R4: A rising `tck` edge with `capture_dr`=1 loads the cells in parallel: enable cells from `core_oe`, data cells from `core_do`, and input cells from `pad_di`. Capture wins over a simultaneous shift.
- R5: A rising edge with neither `capture_dr` nor `shift_dr` leaves every cell unchanged.
- R6: A falling `tck` edge with `update_dr`=1 copies every cell into its update latch. At any other time the latches hold, including while the chain shifts.
- R7: With `mode_extest`=1, each output pin's `pad_oe` comes from its enable latch and its `pad_do` from its data latch. 1 enables the driver and 0 means high impedance.
- R8: With `mode_intest`=1, `core_di` comes from the input-cell latches, and the output pads are driven from the latches as in R7.
- R9: With both mode selects at 0, `pad_oe`=`core_oe`, `pad_do`=`core_do` and `core_di`=`pad_di`, whatever the latches hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous active-low test reset |
| tdi | input | 1 | Serial data into cell 0 |
| capture_dr | input | 1 | Parallel capture strobe (rising edge) |
| shift_dr | input | 1 | Serial shift strobe (rising edge) |
| update_dr | input | 1 | Update-latch strobe (falling edge) |
| mode_extest | input | 1 | External-test mode select |
| mode_intest | input | 1 | Internal-test mode select |
| core_oe | input | N_OUT | Driver enables from the core |
| core_do | input | N_OUT | Output data from the core |
| pad_oe | output | N_OUT | Driver enables to the pads |
| pad_do | output | N_OUT | Output data to the pads |
| pad_di | input | N_IN | Levels arriving from the input pads |
| core_di | output | N_IN | Input levels delivered to the core |
| tdo | output | 1 | Serial data out of the last cell |

## Verification
The assertions check the following on every clock:
- The shift relation between neighbouring cells.
- The parallel capture image.
- Holding when no strobe is active.
- The falling-edge copy into the latches and their stability otherwise.
- The zero state under reset.
- The functional-mode pass-through.

Only the bench scenarios can show two things. The first is that the cell numbering seen at `tdo` matches the pin-to-position mapping. The second is that vectors preloaded in functional mode later appear on the pads and on the core inputs. The bench also covers the capture-over-shift priority and the asynchronous reset in the middle of a run.

// File: rtl/bsr_pkg.sv
package bsr_pkg;

  // cells owned by one output pin: enable then data
  localparam int CELLS_PER_OUT = 2;

  typedef enum logic [1:0] {
    PATH_FUNC   = 2'b00,
    PATH_EXTEST = 2'b01,
    PATH_INTEST = 2'b10
  } path_sel_e;

  function automatic int chain_len(input int n_out, input int n_in);
    return CELLS_PER_OUT * n_out + n_in;
  endfunction

  function automatic int oe_pos(input int k);
    return CELLS_PER_OUT * k;
  endfunction

  function automatic int do_pos(input int k);
    return CELLS_PER_OUT * k + 1;
  endfunction

  function automatic int in_pos(input int n_out, input int j);
    return CELLS_PER_OUT * n_out + j;
  endfunction

endpackage

// File: rtl/bsr_rst_sync.sv
module bsr_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= sync_d;
  end

  assign rst_n = sync_q[STAGES-1];
endmodule

// File: rtl/bsr_cell.sv
module bsr_cell (
  input  logic tck,
  input  logic rst_n,
  input  logic capture_en,
  input  logic shift_en,
  input  logic update_en,
  input  logic cap_val,
  input  logic ser_in,
  output logic ser_q,
  output logic upd_q
);
  logic ser_d;
  logic upd_d;

  // shift stage next state: capture has priority over shift
  always_comb begin
    ser_d = ser_q;
    if (capture_en)    ser_d = cap_val;
    else if (shift_en) ser_d = ser_in;
  end

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n) ser_q <= 1'b0;
    else        ser_q <= ser_d;
  end

  // update latch loads on the falling edge
  always_comb begin
    upd_d = upd_q;
    if (update_en) upd_d = ser_q;
  end

  always_ff @(negedge tck or negedge rst_n) begin
    if (!rst_n) upd_q <= 1'b0;
    else        upd_q <= upd_d;
  end
endmodule

// File: rtl/bsr_out_pin.sv
module bsr_out_pin (
  input  logic       tck,
  input  logic       rst_n,
  input  logic       capture_en,
  input  logic       shift_en,
  input  logic       update_en,
  input  logic       drive_sel,
  input  logic       core_oe,
  input  logic       core_do,
  input  logic [1:0] ser_in,
  output logic [1:0] ser_q,
  output logic [1:0] upd_q,
  output logic       pad_oe,
  output logic       pad_do
);
  logic [1:0] cap_val;

  assign cap_val = {core_do, core_oe};

  for (genvar c = 0; c < 2; c++) begin : g_cell
    bsr_cell u_cell (
      .tck       (tck),
      .rst_n     (rst_n),
      .capture_en(capture_en),
      .shift_en  (shift_en),
      .update_en (update_en),
      .cap_val   (cap_val[c]),
      .ser_in    (ser_in[c]),
      .ser_q     (ser_q[c]),
      .upd_q     (upd_q[c])
    );
  end

  always_comb begin
    if (drive_sel) begin
      pad_oe = upd_q[0];
      pad_do = upd_q[1];
    end else begin
      pad_oe = core_oe;
      pad_do = core_do;
    end
  end
endmodule

// File: rtl/bsr_in_pin.sv
module bsr_in_pin (
  input  logic tck,
  input  logic rst_n,
  input  logic capture_en,
  input  logic shift_en,
  input  logic update_en,
  input  logic feed_sel,
  input  logic pad_di,
  input  logic ser_in,
  output logic ser_q,
  output logic upd_q,
  output logic core_di
);
  bsr_cell u_cell (
    .tck       (tck),
    .rst_n     (rst_n),
    .capture_en(capture_en),
    .shift_en  (shift_en),
    .update_en (update_en),
    .cap_val   (pad_di),
    .ser_in    (ser_in),
    .ser_q     (ser_q),
    .upd_q     (upd_q)
  );

  always_comb begin
    if (feed_sel) core_di = upd_q;
    else          core_di = pad_di;
  end
endmodule

// File: rtl/bsr_chain.sv
module bsr_chain
  import bsr_pkg::*;
#(
  parameter int N_OUT = 3,
  parameter int N_IN  = 2
) (
  input  logic             tck,
  input  logic             trst_n,
  input  logic             tdi,
  input  logic             capture_dr,
  input  logic             shift_dr,
  input  logic             update_dr,
  input  logic             mode_extest,
  input  logic             mode_intest,
  input  logic [N_OUT-1:0] core_oe,
  input  logic [N_OUT-1:0] core_do,
  output logic [N_OUT-1:0] pad_oe,
  output logic [N_OUT-1:0] pad_do,
  input  logic [N_IN-1:0]  pad_di,
  output logic [N_IN-1:0]  core_di,
  output logic             tdo
);
  localparam int N_CELLS = chain_len(N_OUT, N_IN);

  logic               rst_sync_n;
  logic [N_CELLS-1:0] cell_q;
  logic [N_CELLS-1:0] upd_q;
  logic [N_CELLS-1:0] ser_in;
  path_sel_e          path_sel;
  logic               drive_sel;
  logic               feed_sel;

  bsr_rst_sync #(.STAGES(2)) u_rst (
    .clk   (tck),
    .arst_n(trst_n),
    .rst_n (rst_sync_n)
  );

  always_comb begin
    path_sel = PATH_FUNC;
    if (mode_extest)      path_sel = PATH_EXTEST;
    else if (mode_intest) path_sel = PATH_INTEST;
  end

  assign drive_sel = (path_sel != PATH_FUNC);
  assign feed_sel  = (path_sel == PATH_INTEST);

  // serial links: cell 0 at tdi, increasing toward tdo
  assign ser_in[0] = tdi;
  for (genvar i = 1; i < N_CELLS; i++) begin : g_link
    assign ser_in[i] = cell_q[i-1];
  end

  for (genvar k = 0; k < N_OUT; k++) begin : g_out
    localparam int OI = oe_pos(k);
    localparam int DI = do_pos(k);
    bsr_out_pin u_pin (
      .tck       (tck),
      .rst_n     (rst_sync_n),
      .capture_en(capture_dr),
      .shift_en  (shift_dr),
      .update_en (update_dr),
      .drive_sel (drive_sel),
      .core_oe   (core_oe[k]),
      .core_do   (core_do[k]),
      .ser_in    (ser_in[DI:OI]),
      .ser_q     (cell_q[DI:OI]),
      .upd_q     (upd_q[DI:OI]),
      .pad_oe    (pad_oe[k]),
      .pad_do    (pad_do[k])
    );
  end

  for (genvar j = 0; j < N_IN; j++) begin : g_in
    localparam int II = in_pos(N_OUT, j);
    bsr_in_pin u_pin (
      .tck       (tck),
      .rst_n     (rst_sync_n),
      .capture_en(capture_dr),
      .shift_en  (shift_dr),
      .update_en (update_dr),
      .feed_sel  (feed_sel),
      .pad_di    (pad_di[j]),
      .ser_in    (ser_in[II]),
      .ser_q     (cell_q[II]),
      .upd_q     (upd_q[II]),
      .core_di   (core_di[j])
    );
  end

  assign tdo = cell_q[N_CELLS-1];
endmodule

// File: rtl/bsr_chain_chk.sv
module bsr_chain_chk
  import bsr_pkg::*;
#(
  parameter int N_OUT = 3,
  parameter int N_IN  = 2
) (
  input logic                             tck,
  input logic                             rst_sync_n,
  input logic                             tdi,
  input logic                             capture_dr,
  input logic                             shift_dr,
  input logic                             update_dr,
  input logic                             mode_extest,
  input logic                             mode_intest,
  input logic [N_OUT-1:0]                 core_oe,
  input logic [N_OUT-1:0]                 core_do,
  input logic [N_OUT-1:0]                 pad_oe,
  input logic [N_OUT-1:0]                 pad_do,
  input logic [N_IN-1:0]                  pad_di,
  input logic [N_IN-1:0]                  core_di,
  input logic [chain_len(N_OUT,N_IN)-1:0] cell_q,
  input logic [chain_len(N_OUT,N_IN)-1:0] upd_q
);
  localparam int N_CELLS = chain_len(N_OUT, N_IN);

  logic [N_CELLS-1:0] cap_img;
  always_comb begin
    cap_img = '0;
    for (int k = 0; k < N_OUT; k++) begin
      cap_img[oe_pos(k)] = core_oe[k];
      cap_img[do_pos(k)] = core_do[k];
    end
    for (int j = 0; j < N_IN; j++) cap_img[in_pos(N_OUT, j)] = pad_di[j];
  end

  // R2: zero state while reset is held
  a_r2_reset_zero: assert property (@(posedge tck)
    !rst_sync_n |-> (cell_q == '0 && upd_q == '0));

  // R3: one-position shift toward tdo
  a_r3_shift_step: assert property (@(posedge tck) disable iff (!rst_sync_n)
    (shift_dr && !capture_dr) |=>
      (cell_q == {$past(cell_q[N_CELLS-2:0]), $past(tdi)}));

  // R4: parallel capture image, capture wins
  a_r4_capture_image: assert property (@(posedge tck) disable iff (!rst_sync_n)
    capture_dr |=> (cell_q == $past(cap_img)));

  // R5: no strobe, no change
  a_r5_hold: assert property (@(posedge tck) disable iff (!rst_sync_n)
    (!capture_dr && !shift_dr) |=> $stable(cell_q));

  // R6: falling-edge copy into latches
  a_r6_update_copy: assert property (@(negedge tck) disable iff (!rst_sync_n)
    update_dr |=> (upd_q == $past(cell_q)));

  // R6: latches hold without update
  a_r6_latch_hold: assert property (@(negedge tck) disable iff (!rst_sync_n)
    !update_dr |=> $stable(upd_q));

  // R9: functional mode passes pins through
  a_r9_passthrough: assert property (@(posedge tck) disable iff (!rst_sync_n)
    (!mode_extest && !mode_intest) |->
      (pad_oe == core_oe && pad_do == core_do && core_di == pad_di));
endmodule

bind bsr_chain bsr_chain_chk #(.N_OUT(N_OUT), .N_IN(N_IN)) u_chk (
  .tck        (tck),
  .rst_sync_n (rst_sync_n),
  .tdi        (tdi),
  .capture_dr (capture_dr),
  .shift_dr   (shift_dr),
  .update_dr  (update_dr),
  .mode_extest(mode_extest),
  .mode_intest(mode_intest),
  .core_oe    (core_oe),
  .core_do    (core_do),
  .pad_oe     (pad_oe),
  .pad_do     (pad_do),
  .pad_di     (pad_di),
  .core_di    (core_di),
  .cell_q     (cell_q),
  .upd_q      (upd_q)
);

// File: tb/bsr_chain_test.sv
`timescale 1ns/100ps
module bsr_chain_test;
  localparam int NO = 3;
  localparam int NI = 2;
  localparam int NC = 2*NO + NI;

  logic          tck = 1'b0;
  logic          trst_n = 1'b1;
  logic          tdi = 1'b0;
  logic          capture_dr = 1'b0, shift_dr = 1'b0, update_dr = 1'b0;
  logic          mode_extest = 1'b0, mode_intest = 1'b0;
  logic [NO-1:0] core_oe = '0, core_do = '0;
  logic [NO-1:0] pad_oe, pad_do;
  logic [NI-1:0] pad_di = '0;
  logic [NI-1:0] core_di;
  logic          tdo;

  int n_chk = 0;
  int n_fail = 0;

  always #2 tck = ~tck;

  bsr_chain #(.N_OUT(NO), .N_IN(NI)) uut (
    .tck(tck), .trst_n(trst_n), .tdi(tdi),
    .capture_dr(capture_dr), .shift_dr(shift_dr), .update_dr(update_dr),
    .mode_extest(mode_extest), .mode_intest(mode_intest),
    .core_oe(core_oe), .core_do(core_do), .pad_oe(pad_oe), .pad_do(pad_do),
    .pad_di(pad_di), .core_di(core_di), .tdo(tdo)
  );

  // {vector to load, core_oe, core_do, pad_di}
  localparam logic [15:0] TBL [4] = '{
    {8'hA5, 3'b101, 3'b011, 2'b10},
    {8'h3C, 3'b010, 3'b110, 2'b01},
    {8'hFF, 3'b111, 3'b000, 2'b11},
    {8'h00, 3'b000, 3'b111, 2'b00}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // R1 mapping, computed from the requirement
  function automatic logic [NC-1:0] cap_vec(input logic [NO-1:0] oe, input logic [NO-1:0] d,
                                            input logic [NI-1:0] pi);
    logic [NC-1:0] v = '0;
    for (int k = 0; k < NO; k++) begin v[2*k] = oe[k]; v[2*k+1] = d[k]; end
    for (int j = 0; j < NI; j++) v[2*NO+j] = pi[j];
    return v;
  endfunction
  function automatic logic [NO-1:0] oe_of(input logic [NC-1:0] v);
    logic [NO-1:0] r;
    for (int k = 0; k < NO; k++) r[k] = v[2*k];
    return r;
  endfunction
  function automatic logic [NO-1:0] do_of(input logic [NC-1:0] v);
    logic [NO-1:0] r;
    for (int k = 0; k < NO; k++) r[k] = v[2*k+1];
    return r;
  endfunction
  function automatic logic [NI-1:0] in_of(input logic [NC-1:0] v);
    logic [NI-1:0] r;
    for (int j = 0; j < NI; j++) r[j] = v[2*NO+j];
    return r;
  endfunction

  task automatic step();
    @(posedge tck); #1;
  endtask

  task automatic shift_vec(input logic [NC-1:0] vin, output logic [NC-1:0] vout);
    shift_dr = 1'b1;
    for (int i = 0; i < NC; i++) begin
      vout[NC-1-i] = tdo;
      tdi = vin[NC-1-i];
      step();
    end
    shift_dr = 1'b0;
    tdi = 1'b0;
  endtask

  task automatic do_capture();
    capture_dr = 1'b1; step(); capture_dr = 1'b0;
  endtask

  task automatic do_update();
    update_dr = 1'b1;
    @(negedge tck); #1;
    update_dr = 1'b0;
    step();
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge tck);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin : main
    logic [NC-1:0] got;
    logic [NC-1:0] prev_lat;
    #1 trst_n = 1'b0;
    repeat (3) step();
    trst_n = 1'b1;
    repeat (3) step();

    // R2: reset state
    mode_extest = 1'b1; step();
    check("R2 pad_oe after reset", 32'(pad_oe), 32'(0));
    check("R2 pad_do after reset", 32'(pad_do), 32'(0));
    mode_extest = 1'b0; mode_intest = 1'b1; step();
    check("R2 core_di after reset", 32'(core_di), 32'(0));
    mode_intest = 1'b0;
    shift_vec('0, got);
    check("R2 chain after reset", 32'(got), 32'(0));

    prev_lat = '0;
    for (int e = 0; e < 4; e++) begin
      logic [NC-1:0] vec;
      logic [NC-1:0] exp_cap;
      vec = TBL[e][15:8];
      mode_extest = 1'b0; mode_intest = 1'b0;
      core_oe = TBL[e][7:5]; core_do = TBL[e][4:2]; pad_di = TBL[e][1:0];
      step();
      check("R9 pad_oe passthrough", 32'(pad_oe), 32'(core_oe));
      check("R9 pad_do passthrough", 32'(pad_do), 32'(core_do));
      check("R9 core_di passthrough", 32'(core_di), 32'(pad_di));
      exp_cap = cap_vec(core_oe, core_do, pad_di);
      do_capture();
      shift_vec(vec, got);
      check("R4 R1 captured image at tdo", 32'(got), 32'(exp_cap));
      mode_extest = 1'b1; step();
      check("R6 latches hold through shift (oe)", 32'(pad_oe), 32'(oe_of(prev_lat)));
      check("R6 latches hold through shift (do)", 32'(pad_do), 32'(do_of(prev_lat)));
      do_update();
      check("R7 pad_oe from latch", 32'(pad_oe), 32'(oe_of(vec)));
      check("R7 pad_do from latch", 32'(pad_do), 32'(do_of(vec)));
      mode_extest = 1'b0; mode_intest = 1'b1; step();
      check("R8 core_di from latch", 32'(core_di), 32'(in_of(vec)));
      check("R8 pad_oe from latch", 32'(pad_oe), 32'(oe_of(vec)));
      prev_lat = vec;
    end
    mode_intest = 1'b0;

    // R4: capture wins over simultaneous shift
    core_oe = 3'b110; core_do = 3'b001; pad_di = 2'b01;
    capture_dr = 1'b1; shift_dr = 1'b1; tdi = 1'b1; step();
    capture_dr = 1'b0; shift_dr = 1'b0; tdi = 1'b0;
    shift_vec(8'h96, got);
    check("R4 capture priority", 32'(got), 32'(cap_vec(3'b110, 3'b001, 2'b01)));

    // R5: idle cycles keep the chain
    repeat (5) step();
    shift_vec(8'h80, got);
    check("R5 hold while idle", 32'(got), 32'(8'h96));

    // R1 / R3: tdo shows the last cell, one shift step
    check("R1 tdo is last cell", 32'(tdo), 32'(1));
    shift_dr = 1'b1; tdi = 1'b1; step(); shift_dr = 1'b0;
    check("R3 one shift toward tdo", 32'(tdo), 32'(0));
    shift_vec('0, got);
    check("R3 tdi enters cell 0", 32'(got), 32'(8'h01));

    // R2: asynchronous reset mid-run
    shift_vec(8'hFF, got);
    do_update();
    mode_extest = 1'b1; step();
    check("R7 all latches set", 32'(pad_oe), 32'(3'b111));
    #0.5 trst_n = 1'b0;
    #0.5;
    check("R2 async reset clears pad_oe", 32'(pad_oe), 32'(0));
    check("R2 async reset clears pad_do", 32'(pad_do), 32'(0));
    step(); trst_n = 1'b1;
    repeat (3) step();
    mode_extest = 1'b0;
    shift_vec('0, got);
    check("R2 chain cleared by reset", 32'(got), 32'(0));

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule